// File: doc/BRIEF.md
# Multi-Bank Pipe Buffer Status Tracker

This block follows the buffer state of one host-side pipe whose FIFO is divided into one to three equal banks. One side of the pipe is software, which fills banks (OUT direction) or empties them (IN direction) a byte at a time and hands a bank over with a release strobe. The other side is the bus, which sends or receives bytes and signals with a done strobe when a packet has gone out of a bank or has landed in one. Single-cycle strobes stand in for the packet engine, the buffer memory and the register decode.

From these strobes the tracker keeps a running byte count, the index of the bank software is working on, the number of busy banks, a read/write-allowed flag and the data toggle for the current bank. It also raises a one-cycle event when the busy count reaches the point where software should act. An allocation strobe latches the direction, bank count and packet size, checks them against the pipe and FIFO limits, and clears all pipe state. The byte count and bank index outputs trail the allowed flag by one clock. The allowed flag trails the internal state by one clock.

Top module: `pipe_bank_tracker`

## Requirements
- R1: On `alloc_req` the block latches `dir_in`, `cfg_banks` and `cfg_psize`. It clears the count, the bank index, the busy count and the toggles. It sets `cfg_ok` in the next cycle only if 1 ≤ banks ≤ 3, 1 ≤ psize ≤ 1024 and banks × psize ≤ 1536; otherwise it clears `cfg_ok`. While `cfg_ok` is 0, every strobe is ignored and `rw_allowed` is 0.
- R2: OUT pipe (`dir_in`=0 at allocation): `sw_byte` adds one to the count only while the current bank is not busy and holds fewer than psize bytes. `bus_byte` subtracts one only while a bank is busy and the count is non-zero.
- R3: IN pipe (`dir_in`=1): `bus_byte` adds one while fewer than banks banks are busy and the count is below banks × psize. `sw_byte` subtracts one while at least one bank is busy and the count is non-zero.
- R4: An accepted `sw_release` advances the current bank by one, modulo the allocated bank count. `cur_bank` only takes the values 0, 1 or 2.
- R5: The busy count rises on an accepted OUT `sw_release` or IN `bus_done`, and falls on an accepted OUT `bus_done` or IN `sw_release`. A release or done that finds no bank to act on leaves the busy count and the bank index unchanged: OUT release with all banks busy, IN release with none busy, OUT done with none busy, IN done with all busy.
- R6: OUT pipe: `rw_allowed` is 1 while the current bank is neither busy nor holding psize bytes.
- R7: IN pipe: `rw_allowed` is 1 while at least one bank is busy (the current bank holds a packet).
- R8: `rw_allowed` is 0 in the cycle after any cycle in which `stall_rx` or `pipe_err` is 1.
- R9: `busy_banks`, `data_toggle` and `bank_evt` reflect a strobe one clock after it. `rw_allowed` follows one clock later. `byte_count` and `cur_bank` follow one clock after `rw_allowed`.
- R10: `data_toggle` is 0 for DATA0 and 1 for DATA1, and its upper bit is always 0. OUT: it is the toggle of the next packet to send; it starts at 0 and flips on each accepted `bus_done`. IN: it is the `bus_pid` value captured by the `bus_done` that filled the current bank.
- R11: With `evt_en`=1, `bank_evt` pulses for one cycle when an OUT busy count reaches the bank count, or when an IN busy count falls to 0. With `evt_en`=0 it stays 0.
- R12: While `rst` is 1 (synchronous, active high), every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_in | input | 1 | Pipe direction, 1 = IN, latched on allocation |
| alloc_req | input | 1 | Allocation strobe |
| cfg_banks | input | 2 | Requested bank count |
| cfg_psize | input | 11 | Requested packet size in bytes |
| sw_byte | input | 1 | Software wrote (OUT) or read (IN) one byte |
| bus_byte | input | 1 | Bus sent (OUT) or received (IN) one byte |
| sw_release | input | 1 | Software hands over the current bank |
| bus_done | input | 1 | Bus finished a packet in a bank |
| bus_pid | input | 1 | Data toggle of the received packet (IN) |
| stall_rx | input | 1 | Stall-received condition active |
| pipe_err | input | 1 | Pipe error condition active |
| evt_en | input | 1 | Enable for the bank event |
| byte_count | output | 11 | Bytes held in the FIFO |
| cur_bank | output | 2 | Index of the bank software is using |
| busy_banks | output | 2 | Number of busy banks |
| rw_allowed | output | 1 | Software may write (OUT) or read (IN) |
| data_toggle | output | 2 | Data toggle of the current bank |
| cfg_ok | output | 1 | Last allocation passed the limit check |
| bank_evt | output | 1 | One-cycle busy-bank event |

## Verification
The assertions assume the strobes are one-cycle pulses that the source side only issues as the protocol allows. They also assume that `alloc_req` is the only way the configuration changes, so that the bank index and busy count can be required to stay below the latched bank count and to move by at most one per cycle. The stimulus keeps to this: it drives every strobe for exactly one clock from the falling edge, it changes the configuration only through allocation, and it places the deliberately refused releases, dones and bytes on states where the block must hold its value.

// File: rtl/pbt_pkg.sv
package pbt_pkg;

  localparam int BANK_W = 2;

  // next bank index, wrapping at the allocated bank count
  function automatic logic [1:0] bank_next(input logic [1:0] idx, input logic [1:0] nb);
    logic [2:0] s;
    s = {1'b0, idx} + 3'd1;
    if (s >= {1'b0, nb}) s = 3'd0;
    return s[1:0];
  endfunction

  // idx + off modulo nb, with idx < nb and off < nb
  function automatic logic [1:0] bank_add(input logic [1:0] idx, input logic [1:0] off,
                                          input logic [1:0] nb);
    logic [2:0] s;
    s = {1'b0, idx} + {1'b0, off};
    if (s >= {1'b0, nb}) s = s - {1'b0, nb};
    return s[1:0];
  endfunction

endpackage

// File: rtl/pbt_cfg_check.sv
module pbt_cfg_check #(
  parameter int CNT_W      = 11,
  parameter int MAX_BANKS  = 3,
  parameter int MAX_PSIZE  = 1024,
  parameter int FIFO_BYTES = 1536
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_req,
  input  logic             dir_in,
  input  logic [1:0]       cfg_banks,
  input  logic [CNT_W-1:0] cfg_psize,
  output logic             dir_q,
  output logic [1:0]       nb_q,
  output logic [CNT_W-1:0] psize_q,
  output logic [CNT_W-1:0] cap_q,
  output logic             ok_q
);
  localparam logic [1:0]       NB_LIM   = 2'(MAX_BANKS);
  localparam logic [CNT_W-1:0] PS_LIM   = CNT_W'(MAX_PSIZE);
  localparam logic [CNT_W+1:0] FIFO_LIM = (CNT_W+2)'(FIFO_BYTES);

  logic [CNT_W+1:0] prod;
  logic             fits;

  always_comb begin
    prod = (CNT_W+2)'(cfg_banks) * (CNT_W+2)'(cfg_psize);
    fits = (cfg_banks != 2'd0) && (cfg_banks <= NB_LIM) &&
           (cfg_psize != '0) && (cfg_psize <= PS_LIM) && (prod <= FIFO_LIM);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= 1'b0; nb_q <= '0; psize_q <= '0; cap_q <= '0; ok_q <= 1'b0;
    end else if (alloc_req) begin
      dir_q   <= dir_in;
      nb_q    <= cfg_banks;
      psize_q <= cfg_psize;
      cap_q   <= prod[CNT_W-1:0];
      ok_q    <= fits;
    end
  end

  p_ok_limits_r1: assert property (@(posedge clk) disable iff (rst)
    ok_q |-> (nb_q != 2'd0 && nb_q <= NB_LIM && psize_q != '0 && psize_q <= PS_LIM));
  p_alloc_latch_r1: assert property (@(posedge clk) disable iff (rst)
    alloc_req |=> (nb_q == $past(cfg_banks) && psize_q == $past(cfg_psize)));
endmodule

// File: rtl/pbt_bank_ctrl.sv
module pbt_bank_ctrl
  import pbt_pkg::*;
#(
  parameter int MAX_BANKS = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clear,
  input  logic       en,
  input  logic       dir_in,
  input  logic [1:0] nb,
  input  logic       sw_release,
  input  logic       bus_done,
  input  logic       bus_pid,
  input  logic       evt_en,
  output logic [1:0] cur_q,
  output logic [1:0] busy_q,
  output logic [1:0] toggle,
  output logic       evt_q,
  output logic       rel_ok
);
  logic             done_ok, up, dn, out_tog_q;
  logic [1:0]       busy_n, wr_idx;
  logic [MAX_BANKS-1:0] tog_q;

  always_comb begin
    rel_ok  = en && sw_release && (dir_in ? (busy_q != 2'd0) : (busy_q < nb));
    done_ok = en && bus_done   && (dir_in ? (busy_q < nb)    : (busy_q != 2'd0));
    up      = dir_in ? done_ok : rel_ok;
    dn      = dir_in ? rel_ok  : done_ok;
    busy_n  = busy_q + {1'b0, up} - {1'b0, dn};
    wr_idx  = bank_add(cur_q, busy_q, nb);
    toggle  = {1'b0, dir_in ? tog_q[cur_q] : out_tog_q};
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cur_q <= '0; busy_q <= '0; out_tog_q <= 1'b0; evt_q <= 1'b0;
    end else begin
      busy_q <= busy_n;
      if (rel_ok) cur_q <= bank_next(cur_q, nb);
      if (done_ok && !dir_in) out_tog_q <= ~out_tog_q;
      evt_q <= evt_en && (dir_in ? (busy_n == 2'd0 && busy_q != 2'd0)
                                 : (busy_n == nb && busy_q != nb));
    end
  end

  // one stored toggle per bank for received packets
  for (genvar b = 0; b < MAX_BANKS; b++) begin : g_tog
    always_ff @(posedge clk) begin
      if (rst || clear) tog_q[b] <= 1'b0;
      else if (done_ok && dir_in && wr_idx == 2'(b)) tog_q[b] <= bus_pid;
    end
  end

  p_busy_bound_r5: assert property (@(posedge clk) disable iff (rst)
    en |-> busy_q <= nb);
  p_cur_range_r4: assert property (@(posedge clk) disable iff (rst)
    en |-> (cur_q < nb && cur_q != 2'd3));
  p_busy_step_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(clear) |-> (2'(busy_q - $past(busy_q)) != 2'd2));
  p_evt_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    evt_q |=> !evt_q);
endmodule

// File: rtl/pbt_byte_ctr.sv
module pbt_byte_ctr #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             en,
  input  logic             dir_in,
  input  logic             sw_byte,
  input  logic             bus_byte,
  input  logic             rel_ok,
  input  logic [1:0]       busy,
  input  logic [1:0]       nb,
  input  logic [CNT_W-1:0] psize,
  input  logic [CNT_W-1:0] cap,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] fill_q
);
  logic inc, dec;

  always_comb begin
    if (dir_in) begin
      inc = bus_byte && busy < nb && cnt_q < cap;
      dec = sw_byte && busy != 2'd0 && cnt_q != '0;
    end else begin
      inc = sw_byte && busy < nb && fill_q < psize;
      dec = bus_byte && busy != 2'd0 && cnt_q != '0;
    end
    inc = inc && en;
    dec = dec && en;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0; fill_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(inc) - CNT_W'(dec);
      if (rel_ok) fill_q <= '0;
      else if (inc && !dir_in) fill_q <= fill_q + 1'b1;
    end
  end

  p_cnt_cap_r3: assert property (@(posedge clk) disable iff (rst)
    en |-> cnt_q <= cap);
  p_fill_bound_r6: assert property (@(posedge clk) disable iff (rst)
    en |-> fill_q <= psize);
endmodule

// File: rtl/pipe_bank_tracker.sv
module pipe_bank_tracker #(
  parameter int CNT_W      = 11,
  parameter int MAX_BANKS  = 3,
  parameter int MAX_PSIZE  = 1024,
  parameter int FIFO_BYTES = 1536
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dir_in,
  input  logic             alloc_req,
  input  logic [1:0]       cfg_banks,
  input  logic [CNT_W-1:0] cfg_psize,
  input  logic             sw_byte,
  input  logic             bus_byte,
  input  logic             sw_release,
  input  logic             bus_done,
  input  logic             bus_pid,
  input  logic             stall_rx,
  input  logic             pipe_err,
  input  logic             evt_en,
  output logic [CNT_W-1:0] byte_count,
  output logic [1:0]       cur_bank,
  output logic [1:0]       busy_banks,
  output logic             rw_allowed,
  output logic [1:0]       data_toggle,
  output logic             cfg_ok,
  output logic             bank_evt
);
  logic             dir_q, rel_ok, rw_n;
  logic [1:0]       nb_q, cur_q, cur_d1;
  logic [CNT_W-1:0] psize_q, cap_q, cnt_q, cnt_d1, fill_q;

  pbt_cfg_check #(.CNT_W(CNT_W), .MAX_BANKS(MAX_BANKS), .MAX_PSIZE(MAX_PSIZE),
                  .FIFO_BYTES(FIFO_BYTES)) cfg_i (
    .clk(clk), .rst(rst), .alloc_req(alloc_req), .dir_in(dir_in),
    .cfg_banks(cfg_banks), .cfg_psize(cfg_psize), .dir_q(dir_q), .nb_q(nb_q),
    .psize_q(psize_q), .cap_q(cap_q), .ok_q(cfg_ok));

  pbt_bank_ctrl #(.MAX_BANKS(MAX_BANKS)) bank_i (
    .clk(clk), .rst(rst), .clear(alloc_req), .en(cfg_ok), .dir_in(dir_q), .nb(nb_q),
    .sw_release(sw_release), .bus_done(bus_done), .bus_pid(bus_pid), .evt_en(evt_en),
    .cur_q(cur_q), .busy_q(busy_banks), .toggle(data_toggle), .evt_q(bank_evt),
    .rel_ok(rel_ok));

  pbt_byte_ctr #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst(rst), .clear(alloc_req), .en(cfg_ok), .dir_in(dir_q),
    .sw_byte(sw_byte), .bus_byte(bus_byte), .rel_ok(rel_ok), .busy(busy_banks),
    .nb(nb_q), .psize(psize_q), .cap(cap_q), .cnt_q(cnt_q), .fill_q(fill_q));

  always_comb begin
    rw_n = cfg_ok && !stall_rx && !pipe_err &&
           (dir_q ? (busy_banks != 2'd0) : (busy_banks < nb_q && fill_q < psize_q));
  end

  // flag one stage behind state, count and bank index one stage behind the flag
  always_ff @(posedge clk) begin
    if (rst) begin
      rw_allowed <= 1'b0; cnt_d1 <= '0; byte_count <= '0; cur_d1 <= '0; cur_bank <= '0;
    end else begin
      rw_allowed <= rw_n;
      cnt_d1     <= cnt_q;
      byte_count <= cnt_d1;
      cur_d1     <= cur_q;
      cur_bank   <= cur_d1;
    end
  end

  p_rw_block_r8: assert property (@(posedge clk) disable iff (rst)
    (stall_rx || pipe_err) |=> !rw_allowed);
  p_rw_needs_cfg_r1: assert property (@(posedge clk) disable iff (rst)
    !cfg_ok |=> !rw_allowed);
  p_toggle_msb_r10: assert property (@(posedge clk) disable iff (rst)
    data_toggle[1] == 1'b0);
endmodule

// File: tb/pipe_bank_tracker_tb_top.sv
module pipe_bank_tracker_tb_top;
  logic clk = 1'b0, rst = 1'b1;
  logic dir_in = 0, alloc_req = 0, sw_byte = 0, bus_byte = 0, sw_release = 0;
  logic bus_done = 0, bus_pid = 0, stall_rx = 0, pipe_err = 0, evt_en = 0;
  logic [1:0] cfg_banks = 0;
  logic [10:0] cfg_psize = 0;
  logic [10:0] byte_count;
  logic [1:0] cur_bank, busy_banks, data_toggle;
  logic rw_allowed, cfg_ok, bank_evt;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pipe_bank_tracker dut_i (
    .clk(clk), .rst(rst), .dir_in(dir_in), .alloc_req(alloc_req), .cfg_banks(cfg_banks),
    .cfg_psize(cfg_psize), .sw_byte(sw_byte), .bus_byte(bus_byte), .sw_release(sw_release),
    .bus_done(bus_done), .bus_pid(bus_pid), .stall_rx(stall_rx), .pipe_err(pipe_err),
    .evt_en(evt_en), .byte_count(byte_count), .cur_bank(cur_bank), .busy_banks(busy_banks),
    .rw_allowed(rw_allowed), .data_toggle(data_toggle), .cfg_ok(cfg_ok), .bank_evt(bank_evt));

  // {banks, psize, expected cfg_ok}
  localparam int NV = 10;
  localparam logic [13:0] CFG_VEC [NV] = '{
    {2'd1, 11'd1,    1'b1}, {2'd3, 11'd512,  1'b1}, {2'd2, 11'd768, 1'b1},
    {2'd1, 11'd1024, 1'b1}, {2'd2, 11'd1024, 1'b0}, {2'd0, 11'd64,  1'b0},
    {2'd1, 11'd1025, 1'b0}, {2'd3, 11'd0,    1'b0}, {2'd3, 11'd513, 1'b0},
    {2'd2, 11'd64,   1'b1}};

  localparam int S_SWB = 0, S_BUSB = 1, S_REL = 2, S_DONE = 3, S_ALLOC = 4;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int which, input int times);
    for (int i = 0; i < times; i++) begin
      case (which)
        S_SWB:   sw_byte = 1;
        S_BUSB:  bus_byte = 1;
        S_REL:   sw_release = 1;
        S_DONE:  bus_done = 1;
        default: alloc_req = 1;
      endcase
      @(negedge clk);
      sw_byte = 0; bus_byte = 0; sw_release = 0; bus_done = 0; alloc_req = 0;
    end
  endtask

  task automatic alloc(input logic d, input logic [1:0] nb, input logic [10:0] ps);
    dir_in = d; cfg_banks = nb; cfg_psize = ps;
    pulse(S_ALLOC, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    settle(3);
    // R12 reset state
    chk("R12 cfg_ok", cfg_ok, 0); chk("R12 rw", rw_allowed, 0);
    chk("R12 count", byte_count, 0); chk("R12 busy", busy_banks, 0);
    chk("R12 cur", cur_bank, 0); chk("R12 evt", bank_evt, 0);
    rst = 0;
    settle(1);
    // R1 strobes ignored before allocation
    pulse(S_SWB, 2); pulse(S_REL, 1); settle(3);
    chk("R1 no cfg count", byte_count, 0); chk("R1 no cfg busy", busy_banks, 0);
    chk("R1 no cfg rw", rw_allowed, 0);

    // R1 limit table
    for (int v = 0; v < NV; v++) begin
      alloc(1'b0, CFG_VEC[v][13:12], CFG_VEC[v][11:1]);
      chk("R1 cfg_ok vector", cfg_ok, int'(CFG_VEC[v][0]));
    end

    // OUT pipe, 2 banks of 4 bytes
    evt_en = 1;
    alloc(1'b0, 2'd2, 11'd4);
    settle(2);
    chk("R1 out ok", cfg_ok, 1); chk("R6 out empty rw", rw_allowed, 1);
    chk("R10 out toggle start", data_toggle, 0);
    pulse(S_SWB, 4); settle(3);
    chk("R2 out count", byte_count, 4); chk("R6 out full rw", rw_allowed, 0);
    pulse(S_SWB, 1); settle(3);
    chk("R2 out full ignored", byte_count, 4);
    // R9 lag ordering on a release
    pulse(S_REL, 1);
    chk("R9 busy first", busy_banks, 1); chk("R9 rw not yet", rw_allowed, 0);
    chk("R9 cur not yet", cur_bank, 0); chk("R11 no evt", bank_evt, 0);
    settle(1);
    chk("R9 rw second", rw_allowed, 1); chk("R9 cur still old", cur_bank, 0);
    settle(1);
    chk("R9 cur third", cur_bank, 1);
    pulse(S_SWB, 2); pulse(S_REL, 1);
    chk("R5 out busy 2", busy_banks, 2); chk("R11 out evt", bank_evt, 1);
    settle(1);
    chk("R11 evt one cycle", bank_evt, 0);
    settle(2);
    chk("R4 out wrap", cur_bank, 0); chk("R6 all busy rw", rw_allowed, 0);
    chk("R2 out count 6", byte_count, 6);
    pulse(S_REL, 1); settle(3);
    chk("R5 out release refused", busy_banks, 2); chk("R5 cur held", cur_bank, 0);
    pulse(S_BUSB, 3); pulse(S_DONE, 1);
    chk("R5 out done", busy_banks, 1); chk("R10 out toggle flip", data_toggle, 1);
    settle(3);
    chk("R2 out drained", byte_count, 3); chk("R6 out reopened", rw_allowed, 1);
    stall_rx = 1; settle(1);
    chk("R8 stall", rw_allowed, 0);
    stall_rx = 0; settle(1);
    chk("R8 stall gone", rw_allowed, 1);
    pulse(S_DONE, 1); chk("R10 out toggle back", data_toggle, 0);
    pulse(S_DONE, 1); settle(1);
    chk("R5 out done refused", busy_banks, 0); chk("R10 toggle held", data_toggle, 0);

    // IN pipe, 3 banks of 8 bytes
    alloc(1'b1, 2'd3, 11'd8);
    settle(2);
    chk("R7 in empty rw", rw_allowed, 0);
    pulse(S_BUSB, 3); bus_pid = 1; pulse(S_DONE, 1);
    chk("R5 in busy 1", busy_banks, 1); chk("R10 in pid 1", data_toggle, 1);
    settle(3);
    chk("R7 in rw", rw_allowed, 1); chk("R3 in count", byte_count, 3);
    pulse(S_BUSB, 2); bus_pid = 0; pulse(S_DONE, 1);
    chk("R10 in current bank pid", data_toggle, 1);
    bus_pid = 1; pulse(S_DONE, 1); bus_pid = 0; pulse(S_DONE, 1);
    chk("R5 in done refused", busy_banks, 3);
    pulse(S_BUSB, 1); settle(3);
    chk("R3 in full ignored", byte_count, 5);
    pulse(S_SWB, 6); settle(3);
    chk("R3 in drained", byte_count, 0);
    pulse(S_REL, 1); settle(2);
    chk("R5 in release", busy_banks, 2); chk("R4 in cur 1", cur_bank, 1);
    chk("R10 in bank1 pid", data_toggle, 0);
    pulse(S_REL, 1); chk("R10 in bank2 pid", data_toggle, 1);
    pulse(S_REL, 1);
    chk("R11 in evt", bank_evt, 1); chk("R5 in none busy", busy_banks, 0);
    settle(3);
    chk("R4 in wrap", cur_bank, 0); chk("R7 in empty again", rw_allowed, 0);
    pulse(S_REL, 1); settle(3);
    chk("R5 in release refused", cur_bank, 0);
    pulse(S_DONE, 1); settle(1);
    chk("R7 in rw again", rw_allowed, 1);
    pipe_err = 1; settle(1);
    chk("R8 error", rw_allowed, 0);
    pipe_err = 0;
    evt_en = 0; pulse(S_REL, 1);
    chk("R11 gated", bank_evt, 0); chk("R5 in busy 0", busy_banks, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule